// File: doc/BRIEF.md
# Redundant Thread Load Replay Queue

Two hardware threads run the same program for fault detection. Only the leading thread reads memory. Each load that the leading thread commits is written here with its address and the value memory returned. The write takes the next sequence tag, which wraps modulo the depth. The trailing thread never reads memory. It fetches each load value from this queue by sequence tag, so both threads see the same data even when memory changes between the two executions. The trailing thread may present its loads in any order.

On each trailing lookup, the block compares the address the trailing thread computed with the address stored in the entry. A difference means one of the two threads was corrupted, and the block flags it for one cycle. It still returns the stored value. An entry frees its slot only after it has been consumed and every older entry has already been freed. When all slots are in use, the leading thread is stalled.

Top module: `load_replica_queue`

## Requirements
- R1: Reset state: `lead_ready` = 1, `lead_tag` = 0, `trail_ready` = 0, `rsp_valid` = 0 and `rsp_fault` = 0.
- R2: An insert (`lead_valid` and `lead_ready` high at a clock edge) takes the tag shown on `lead_tag`. After the edge, `lead_tag` advances by one and wraps from DEPTH-1 back to 0.
- R3: `trail_ready` is high, in the same cycle, whenever `trail_tag` names an entry that has been inserted and not yet consumed. When such a request is accepted, the next cycle shows `rsp_valid` = 1 and `rsp_data` equal to the value inserted under that tag.
- R4: Lookups may come in any order. Each one returns the value of the tag it names.
- R5: A tag that was never inserted, or has already been consumed, gives `trail_ready` = 0. A request on that tag produces no response on the next cycle.
- R6: If the trailing address differs from the stored address, `rsp_fault` is 1 for exactly the one response cycle. `rsp_data` still carries the stored value. Matching addresses give `rsp_fault` = 0.
- R7: After DEPTH inserts with no slot freed, `lead_ready` is 0. A further insert attempt is ignored: `lead_tag` does not move, and the stored entries are unchanged.
- R8: Slots are freed oldest first, at most one per cycle, one cycle after the oldest entry is consumed. Consuming a younger entry while the oldest is still outstanding frees nothing, so `lead_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lead_valid | input | 1 | Leading thread offers a committed load |
| lead_addr | input | ADDR_W | Address of the committed load |
| lead_data | input | DATA_W | Value returned by memory |
| lead_ready | output | 1 | A free slot exists |
| lead_tag | output | TAG_W | Tag the next insert receives |
| trail_req | input | 1 | Trailing thread requests a load value |
| trail_tag | input | TAG_W | Sequence tag of the trailing load |
| trail_addr | input | ADDR_W | Address computed by the trailing thread |
| trail_ready | output | 1 | Entry for `trail_tag` is present and unconsumed |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_data | output | DATA_W | Replicated load value |
| rsp_fault | output | 1 | Address mismatch on this response |

## Verification
`lead_ready`, `lead_tag` and `trail_ready` are checked just before the clock edge that would use them. Each accepted lookup's `rsp_valid`, `rsp_data` and `rsp_fault` are sampled one time unit after that edge, which is the single register stage they pass through. A freed slot shows up in `lead_ready` one edge after the consuming edge, so the bench inserts one idle edge before it checks the stall. The queue is filled to depth, drained in a scrambled order with a planted mismatch on a fixed subset of tags, and then filled again to cover tag wraparound.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_LIVE = 2'd1,
      SLOT_USED = 2'd2
   } slot_state_e;
endpackage

// File: rtl/lrq_order.sv
module lrq_order #(
   parameter int DEPTH = 16,
   localparam int TAG_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             retire,
   output logic [TAG_W-1:0] head,
   output logic [TAG_W-1:0] tail,
   output logic             full
);
   localparam int CNT_W = TAG_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head    <= '0;
         tail    <= '0;
         count_q <= '0;
      end else begin
         if (push)   head <= head + 1'b1;
         if (retire) tail <= tail + 1'b1;
         case ({push, retire})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign full = (count_q == CNT_MAX);
endmodule

// File: rtl/lrq_store.sv
module lrq_store
   import lrq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int TAG_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic              use_en,
   input  logic              ret_en,
   input  logic [TAG_W-1:0]  ret_tag,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_live,
   output logic              oldest_used
);
   slot_state_e       state_q [DEPTH];
   logic [ADDR_W-1:0] addr_q  [DEPTH];
   logic [DATA_W-1:0] data_q  [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      localparam logic [TAG_W-1:0] ME = TAG_W'(s);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state_q[s] <= SLOT_FREE;
         end else if (wr_en && wr_tag == ME) begin
            state_q[s] <= SLOT_LIVE;
         end else if (use_en && rd_tag == ME) begin
            state_q[s] <= SLOT_USED;
         end else if (ret_en && ret_tag == ME) begin
            state_q[s] <= SLOT_FREE;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && wr_tag == ME) begin
            addr_q[s] <= wr_addr;
            data_q[s] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_addr     = addr_q[rd_tag];
      rd_data     = data_q[rd_tag];
      rd_live     = (state_q[rd_tag] == SLOT_LIVE);
      oldest_used = (state_q[ret_tag] == SLOT_USED);
   end
endmodule

// File: rtl/lrq_compare.sv
module lrq_compare #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] stored_addr,
   input  logic [ADDR_W-1:0] probe_addr,
   input  logic [DATA_W-1:0] stored_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_fault
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= accept;
         rsp_fault <= accept && (stored_addr != probe_addr);
         if (accept) rsp_data <= stored_data;
      end
   end
endmodule

// File: rtl/load_replica_queue.sv
module load_replica_queue #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int TAG_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lead_valid,
   input  logic [ADDR_W-1:0] lead_addr,
   input  logic [DATA_W-1:0] lead_data,
   output logic              lead_ready,
   output logic [TAG_W-1:0]  lead_tag,
   input  logic              trail_req,
   input  logic [TAG_W-1:0]  trail_tag,
   input  logic [ADDR_W-1:0] trail_addr,
   output logic              trail_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_fault
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ADDR_W and DATA_W must be positive");
   end

   logic              full;
   logic              push;
   logic              accept;
   logic              retire;
   logic [TAG_W-1:0]  tail;
   logic [ADDR_W-1:0] stored_addr;
   logic [DATA_W-1:0] stored_data;

   assign lead_ready = !full;
   assign push       = lead_valid && !full;
   assign accept     = trail_req && trail_ready;

   lrq_order #(.DEPTH(DEPTH)) u_order (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push),
      .retire (retire),
      .head   (lead_tag),
      .tail   (tail),
      .full   (full)
   );

   lrq_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (push),
      .wr_tag      (lead_tag),
      .wr_addr     (lead_addr),
      .wr_data     (lead_data),
      .rd_tag      (trail_tag),
      .use_en      (accept),
      .ret_en      (retire),
      .ret_tag     (tail),
      .rd_addr     (stored_addr),
      .rd_data     (stored_data),
      .rd_live     (trail_ready),
      .oldest_used (retire)
   );

   lrq_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .stored_addr (stored_addr),
      .probe_addr  (trail_addr),
      .stored_data (stored_data),
      .rsp_valid   (rsp_valid),
      .rsp_data    (rsp_data),
      .rsp_fault   (rsp_fault)
   );
endmodule

// File: rtl/lrq_checker.sv
module lrq_checker #(
   parameter int TAG_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lead_valid,
   input logic             lead_ready,
   input logic [TAG_W-1:0] lead_tag,
   input logic             trail_req,
   input logic             trail_ready,
   input logic             rsp_valid,
   input logic             rsp_fault
);
   AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      lead_valid && lead_ready |=> lead_tag == $past(lead_tag) + 1'b1); // R2
   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      trail_req && trail_ready |=> rsp_valid); // R3
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(trail_req && trail_ready) |=> !rsp_valid); // R5
   AST_FAULT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_valid); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      lead_valid && !lead_ready |=> $stable(lead_tag)); // R7
endmodule

bind load_replica_queue lrq_checker #(.TAG_W(TAG_W)) u_lrq_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .lead_valid  (lead_valid),
   .lead_ready  (lead_ready),
   .lead_tag    (lead_tag),
   .trail_req   (trail_req),
   .trail_ready (trail_ready),
   .rsp_valid   (rsp_valid),
   .rsp_fault   (rsp_fault)
);

// File: tb/test_load_replica_queue.sv
`timescale 1ns/1ps
module test_load_replica_queue;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int DEPTH = 16;
   localparam int TW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lead_valid = 1'b0;
   logic [AW-1:0] lead_addr = '0;
   logic [DW-1:0] lead_data = '0;
   logic lead_ready;
   logic [TW-1:0] lead_tag;
   logic trail_req = 1'b0;
   logic [TW-1:0] trail_tag = '0;
   logic [AW-1:0] trail_addr = '0;
   logic trail_ready;
   logic rsp_valid;
   logic [DW-1:0] rsp_data;
   logic rsp_fault;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   load_replica_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) i_load_replica_queue (
      .clk(clk), .rst_n(rst_n),
      .lead_valid(lead_valid), .lead_addr(lead_addr), .lead_data(lead_data),
      .lead_ready(lead_ready), .lead_tag(lead_tag),
      .trail_req(trail_req), .trail_tag(trail_tag), .trail_addr(trail_addr),
      .trail_ready(trail_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault)
   );

   function automatic logic [AW-1:0] addr_of(int n);
      return 32'h0000_1000 + 32'(n) * 4;
   endfunction
   function automatic logic [DW-1:0] data_of(int n);
      return (32'(n) * 32'h0101_0101) ^ 32'hA5C3_0000;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
      lead_valid = 1'b1; lead_addr = a; lead_data = d;
      @(posedge clk); #1;
      lead_valid = 1'b0;
   endtask

   task automatic lookup(input int tag, input logic [AW-1:0] a, input logic [DW-1:0] exp_d, input bit exp_f);
      trail_req = 1'b1; trail_tag = TW'(tag); trail_addr = a;
      #1;
      check(trail_ready == 1'b1, "R3 ready", 64'(trail_ready), 64'd1);
      @(posedge clk); #1;
      trail_req = 1'b0;
      check(rsp_valid == 1'b1, "R3 rsp_valid", 64'(rsp_valid), 64'd1);
      check(rsp_data == exp_d, "R4 rsp_data", 64'(rsp_data), 64'(exp_d));
      check(rsp_fault == exp_f, "R6 rsp_fault", 64'(rsp_fault), 64'(exp_f));
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values
      check(lead_ready == 1'b1, "R1 lead_ready", 64'(lead_ready), 64'd1);
      check(lead_tag == '0, "R1 lead_tag", 64'(lead_tag), 64'd0);
      check(trail_ready == 1'b0, "R1 trail_ready", 64'(trail_ready), 64'd0);
      check(rsp_valid == 1'b0 && rsp_fault == 1'b0, "R1 rsp", 64'({rsp_valid, rsp_fault}), 64'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R2 sequential tags, fill to depth
      for (int i = 0; i < DEPTH; i++) begin
         check(lead_tag == TW'(i), "R2 tag order", 64'(lead_tag), 64'(i));
         push(addr_of(i), data_of(i));
      end
      // R7 full stall and ignored insert
      check(lead_ready == 1'b0, "R7 full", 64'(lead_ready), 64'd0);
      push(32'hDEAD_BEEF, 32'hBAD0_BAD0);
      check(lead_tag == '0, "R7 tag held", 64'(lead_tag), 64'd0);

      // R4 scrambled drain, R6 planted mismatches, R8 ordered freeing
      for (int i = 0; i < DEPTH; i++) begin
         int t;
         bit bad;
         t = (i * 7 + 3) % DEPTH;
         bad = (t % 5 == 3);
         lookup(t, bad ? (addr_of(t) ^ 32'h10) : addr_of(t), data_of(t), bad);
         @(posedge clk); #1;
         // R6 fault lasts one cycle
         check(rsp_fault == 1'b0, "R6 fault pulse", 64'(rsp_fault), 64'd0);
         if (t != 0 && i < 11)
            check(lead_ready == 1'b0, "R8 young consume frees nothing", 64'(lead_ready), 64'd0);
         // R5 consumed tag no longer ready
         trail_tag = TW'(t); #1;
         check(trail_ready == 1'b0, "R5 consumed", 64'(trail_ready), 64'd0);
      end
      repeat (DEPTH + 2) @(posedge clk);
      #1;
      check(lead_ready == 1'b1, "R8 freed", 64'(lead_ready), 64'd1);

      // R5 request on absent tag gives no response
      trail_req = 1'b1; trail_tag = 4'd5; trail_addr = addr_of(5);
      #1;
      check(trail_ready == 1'b0, "R5 absent ready", 64'(trail_ready), 64'd0);
      @(posedge clk); #1;
      trail_req = 1'b0;
      check(rsp_valid == 1'b0, "R5 no rsp", 64'(rsp_valid), 64'd0);

      // R2 wraparound: tags restart at 0
      for (int i = 0; i < 3; i++) begin
         check(lead_tag == TW'(i), "R2 wrap", 64'(lead_tag), 64'(i));
         push(addr_of(100 + i), data_of(100 + i));
      end
      lookup(2, addr_of(102), data_of(102), 1'b0);
      lookup(0, addr_of(100), data_of(100), 1'b0);
      lookup(1, addr_of(999), data_of(101), 1'b1);
      repeat (4) @(posedge clk);
      #1;
      check(lead_tag == 4'd3, "R2 tag after wrap", 64'(lead_tag), 64'd3);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule